// File: doc/BRIEF.md
# Half-Addressable Dual-Write Register File

This block is a small data register file: eight 32-bit registers that can be read and written at word or half-word granularity. Each of the four ports (two read, two write) names a register with a 3-bit index and chooses what it accesses with a 2-bit mode: the whole word, the upper half, the lower half, or nothing at all. Seen half by half, the same storage behaves like sixteen 16-bit registers.

Both read ports are combinational views of the stored state, so they always show the contents from before any write in the same cycle. Both write ports commit on the rising clock edge. When the two writers touch the same half of the same register, write port 1 takes priority. When they touch different halves of one register, both halves update. A synchronous active-high reset clears the whole array.

Top module: `hrf_dual_file`

## Requirements
- R1: While `rst` is high at a rising edge, all eight registers become zero. This is independent of the write ports.
- R2: Mode encoding on every port: 2'b00 selects the full word, 2'b01 the high half [31:16], 2'b10 the low half [15:0], and 2'b11 is idle. A full read returns all 32 bits of the indexed register.
- R3: A high or low read returns the selected half in `rdN_data[15:0]` with `rdN_data[31:16]` zero. An idle read returns zero.
- R4: A full write stores all 32 bits of `wrN_data` into the indexed register at the next rising edge.
- R5: A high or low write stores `wrN_data[15:0]` into the selected half and leaves the other half of that register unchanged.
- R6: An idle write changes no register, whatever its index and data are.
- R7: Two writes in one cycle to different registers both take effect.
- R8: When both write ports update the same half of the same register, that half takes the value from write port 1.
- R9: When both write ports hit the same register on disjoint halves (one high, one low), both halves update.
- R10: A read in the same cycle as a write to the same location returns the old value. The new value is visible from the following cycle.
- R11: The two read ports are independent. Any index and mode combination is allowed, including both ports reading the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_mode | input | 2 | Read port 0 access mode |
| rd0_data | output | 32 | Read port 0 data |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_mode | input | 2 | Read port 1 access mode |
| rd1_data | output | 32 | Read port 1 data |
| wr0_idx | input | 3 | Write port 0 register index |
| wr0_mode | input | 2 | Write port 0 access mode |
| wr0_data | input | 32 | Write port 0 data |
| wr1_idx | input | 3 | Write port 1 register index (priority port) |
| wr1_mode | input | 2 | Write port 1 access mode |
| wr1_data | input | 32 | Write port 1 data |

## Verification
The bench targets half writes first. A design that fails to preserve the untouched half would corrupt the neighbouring half-register, and one that takes the source half from the wrong bits would store the upper data bits. It also collides the two writers on the same half and on disjoint halves of one register. Reversing the priority shows up as port 0's value surviving, and a whole-register priority rule shows up as a lost half. Same-cycle read-after-write probes catch any forwarding path, because such a path would return the new value one cycle early. Idle writes that carry matching indices and non-zero data catch a decoder that ignores the idle code.

// File: rtl/hrf_pkg.sv
package hrf_pkg;
    typedef enum logic [1:0] {
        ACC_FULL = 2'b00,
        ACC_HIGH = 2'b01,
        ACC_LOW  = 2'b10,
        ACC_IDLE = 2'b11
    } acc_mode_e;
endpackage

// File: rtl/hrf_write_decode.sv
module hrf_write_decode #(
    parameter int NREG = 8,
    localparam int IW = $clog2(NREG)
) (
    input  logic [IW-1:0]   idx,
    input  logic [1:0]      mode,
    output logic [NREG-1:0] hi_hit,
    output logic [NREG-1:0] lo_hit
);
    import hrf_pkg::*;

    logic hi_sel;
    logic lo_sel;

    always_comb begin
        unique case (acc_mode_e'(mode))
            ACC_FULL: begin hi_sel = 1'b1; lo_sel = 1'b1; end
            ACC_HIGH: begin hi_sel = 1'b1; lo_sel = 1'b0; end
            ACC_LOW:  begin hi_sel = 1'b0; lo_sel = 1'b1; end
            ACC_IDLE: begin hi_sel = 1'b0; lo_sel = 1'b0; end
            default:  begin hi_sel = 1'b0; lo_sel = 1'b0; end
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hi_hit[g] = hi_sel && (idx == IW'(g));
        assign lo_hit[g] = lo_sel && (idx == IW'(g));
    end
endmodule

// File: rtl/hrf_word.sv
module hrf_word #(
    parameter int W = 32,
    localparam int HW = W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hi_en0,
    input  logic          lo_en0,
    input  logic          hi_en1,
    input  logic          lo_en1,
    input  logic [HW-1:0] hi_d0,
    input  logic [HW-1:0] lo_d0,
    input  logic [HW-1:0] hi_d1,
    input  logic [HW-1:0] lo_d1,
    output logic [W-1:0]  q
);
    logic [HW-1:0] hi_q;
    logic [HW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
        end else if (hi_en1) begin
            hi_q <= hi_d1;
        end else if (hi_en0) begin
            hi_q <= hi_d0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (lo_en1) begin
            lo_q <= lo_d1;
        end else if (lo_en0) begin
            lo_q <= lo_d0;
        end
    end

    assign q = {hi_q, lo_q};
endmodule

// File: rtl/hrf_read_port.sv
module hrf_read_port #(
    parameter int NREG = 8,
    parameter int W = 32,
    localparam int IW = $clog2(NREG),
    localparam int HW = W / 2
) (
    input  logic [W-1:0]  regs [NREG],
    input  logic [IW-1:0] idx,
    input  logic [1:0]    mode,
    output logic [W-1:0]  data
);
    import hrf_pkg::*;

    logic [W-1:0] word;

    assign word = regs[idx];

    always_comb begin
        unique case (acc_mode_e'(mode))
            ACC_FULL: data = word;
            ACC_HIGH: data = {{HW{1'b0}}, word[W-1:HW]};
            ACC_LOW:  data = {{HW{1'b0}}, word[HW-1:0]};
            ACC_IDLE: data = '0;
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/hrf_dual_file.sv
module hrf_dual_file #(
    parameter int NREG = 8,
    parameter int W = 32,
    localparam int IW = $clog2(NREG),
    localparam int HW = W / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd0_idx,
    input  logic [1:0]    rd0_mode,
    output logic [W-1:0]  rd0_data,
    input  logic [IW-1:0] rd1_idx,
    input  logic [1:0]    rd1_mode,
    output logic [W-1:0]  rd1_data,
    input  logic [IW-1:0] wr0_idx,
    input  logic [1:0]    wr0_mode,
    input  logic [W-1:0]  wr0_data,
    input  logic [IW-1:0] wr1_idx,
    input  logic [1:0]    wr1_mode,
    input  logic [W-1:0]  wr1_data
);
    import hrf_pkg::*;

    logic [NREG-1:0] hi_hit0, lo_hit0, hi_hit1, lo_hit1;
    logic [HW-1:0]   hi_src0, hi_src1;
    logic [W-1:0]    regs [NREG];

    hrf_write_decode #(.NREG(NREG)) u_dec0 (
        .idx(wr0_idx), .mode(wr0_mode), .hi_hit(hi_hit0), .lo_hit(lo_hit0)
    );
    hrf_write_decode #(.NREG(NREG)) u_dec1 (
        .idx(wr1_idx), .mode(wr1_mode), .hi_hit(hi_hit1), .lo_hit(lo_hit1)
    );

    // A full write feeds the upper half from the upper data bits;
    // a half write always takes its value from the lower data bits.
    assign hi_src0 = (acc_mode_e'(wr0_mode) == ACC_FULL) ? wr0_data[W-1:HW] : wr0_data[HW-1:0];
    assign hi_src1 = (acc_mode_e'(wr1_mode) == ACC_FULL) ? wr1_data[W-1:HW] : wr1_data[HW-1:0];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        hrf_word #(.W(W)) u_word (
            .clk   (clk),
            .rst   (rst),
            .hi_en0(hi_hit0[g]),
            .lo_en0(lo_hit0[g]),
            .hi_en1(hi_hit1[g]),
            .lo_en1(lo_hit1[g]),
            .hi_d0 (hi_src0),
            .lo_d0 (wr0_data[HW-1:0]),
            .hi_d1 (hi_src1),
            .lo_d1 (wr1_data[HW-1:0]),
            .q     (regs[g])
        );
    end

    hrf_read_port #(.NREG(NREG), .W(W)) u_rp0 (
        .regs(regs), .idx(rd0_idx), .mode(rd0_mode), .data(rd0_data)
    );
    hrf_read_port #(.NREG(NREG), .W(W)) u_rp1 (
        .regs(regs), .idx(rd1_idx), .mode(rd1_mode), .data(rd1_data)
    );
endmodule

// File: rtl/hrf_checker.sv
module hrf_checker #(
    parameter int NREG = 8,
    parameter int W = 32,
    localparam int IW = $clog2(NREG),
    localparam int HW = W / 2
) (
    input logic          clk,
    input logic          rst,
    input logic [IW-1:0] rd0_idx,
    input logic [1:0]    rd0_mode,
    input logic [W-1:0]  rd0_data,
    input logic [IW-1:0] rd1_idx,
    input logic [1:0]    rd1_mode,
    input logic [W-1:0]  rd1_data,
    input logic [IW-1:0] wr0_idx,
    input logic [1:0]    wr0_mode,
    input logic [W-1:0]  wr0_data,
    input logic [IW-1:0] wr1_idx,
    input logic [1:0]    wr1_mode,
    input logic [W-1:0]  wr1_data
);
    logic miss0, miss1;
    assign miss0 = (wr0_mode == 2'b11) || (wr0_idx != rd0_idx);
    assign miss1 = (wr1_mode == 2'b11) || (wr1_idx != rd0_idx);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd0_data == '0 && rd1_data == '0)); // R1

    AST_HALF_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd0_mode != 2'b00) |-> (rd0_data[W-1:HW] == '0)); // R3

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd1_mode == 2'b11) |-> (rd1_data == '0)); // R3

    AST_PRIORITY_FULL_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr1_mode == 2'b00) |=> ((rd0_idx != $past(wr1_idx)) || (rd0_mode != 2'b00)
                                 || (rd0_data == $past(wr1_data)))); // R8

    AST_UNTOUCHED_STABLE: assert property (@(posedge clk) disable iff (rst)
        (miss0 && miss1) |=> ((rd0_idx != $past(rd0_idx)) || (rd0_mode != $past(rd0_mode))
                              || $stable(rd0_data))); // R6
endmodule

bind hrf_dual_file hrf_checker #(.NREG(NREG), .W(W)) u_hrf_checker (
    .clk(clk), .rst(rst),
    .rd0_idx(rd0_idx), .rd0_mode(rd0_mode), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_mode(rd1_mode), .rd1_data(rd1_data),
    .wr0_idx(wr0_idx), .wr0_mode(wr0_mode), .wr0_data(wr0_data),
    .wr1_idx(wr1_idx), .wr1_mode(wr1_mode), .wr1_data(wr1_data)
);

// File: tb/tb_hrf_dual_file.sv
`timescale 1ns/1ps
module tb_hrf_dual_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  rd0_idx = '0, rd1_idx = '0, wr0_idx = '0, wr1_idx = '0;
    logic [1:0]  rd0_mode = 2'b11, rd1_mode = 2'b11, wr0_mode = 2'b11, wr1_mode = 2'b11;
    logic [31:0] rd0_data, rd1_data;
    logic [31:0] wr0_data = '0, wr1_data = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [8];
    logic [31:0] lfsr = 32'h1ACE_5EED;
    bit done = 0;

    always #4 clk = ~clk;

    hrf_dual_file dut (
        .clk(clk), .rst(rst),
        .rd0_idx(rd0_idx), .rd0_mode(rd0_mode), .rd0_data(rd0_data),
        .rd1_idx(rd1_idx), .rd1_mode(rd1_mode), .rd1_data(rd1_data),
        .wr0_idx(wr0_idx), .wr0_mode(wr0_mode), .wr0_data(wr0_data),
        .wr1_idx(wr1_idx), .wr1_mode(wr1_mode), .wr1_data(wr1_data)
    );

    function automatic logic [31:0] expect_rd(input logic [2:0] i, input logic [1:0] m);
        case (m)
            2'b00:   return mdl[i];
            2'b01:   return {16'h0, mdl[i][31:16]};
            2'b10:   return {16'h0, mdl[i][15:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] apply_wr(input logic [31:0] cur, input logic [1:0] m,
                                             input logic [31:0] d);
        case (m)
            2'b00:   return d;
            2'b01:   return {d[15:0], cur[15:0]};
            2'b10:   return {cur[31:16], d[15:0]};
            default: return cur;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // drive one cycle, check reads before the edge, update the model after it
    task automatic step(input string tag,
                        input logic [2:0] ri0, input logic [1:0] rm0,
                        input logic [2:0] ri1, input logic [1:0] rm1,
                        input logic [2:0] wi0, input logic [1:0] wm0, input logic [31:0] wd0,
                        input logic [2:0] wi1, input logic [1:0] wm1, input logic [31:0] wd1);
        @(negedge clk);
        rd0_idx = ri0; rd0_mode = rm0; rd1_idx = ri1; rd1_mode = rm1;
        wr0_idx = wi0; wr0_mode = wm0; wr0_data = wd0;
        wr1_idx = wi1; wr1_mode = wm1; wr1_data = wd1;
        #1;
        check(tag, rd0_data, expect_rd(ri0, rm0));
        check(tag, rd1_data, expect_rd(ri1, rm1));
        @(posedge clk);
        #1;
        if (rst) begin
            for (int k = 0; k < 8; k++) mdl[k] = '0;
        end else begin
            mdl[wi0] = apply_wr(mdl[wi0], wm0, wd0);
            mdl[wi1] = apply_wr(mdl[wi1], wm1, wd1);
        end
    endtask

    task automatic idle_read(input string tag, input logic [2:0] i, input logic [1:0] m);
        step(tag, i, m, i, 2'b00, 3'd0, 2'b11, 32'h0, 3'd0, 2'b11, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) mdl[k] = 'x;
        // R1: reset clears everything even with active writes
        step("R1", 3'd0, 2'b11, 3'd0, 2'b11, 3'd2, 2'b00, 32'hFFFF_FFFF, 3'd5, 2'b00, 32'h1234_5678);
        step("R1", 3'd0, 2'b11, 3'd0, 2'b11, 3'd0, 2'b11, 32'h0, 3'd0, 2'b11, 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++)
            for (int m = 0; m < 4; m++) idle_read("R1", 3'(i), 2'(m));

        // R4 R7: full writes on both ports to distinct registers
        for (int i = 0; i < 8; i += 2)
            step("R7", 3'd0, 2'b11, 3'd0, 2'b11, 3'(i), 2'b00, 32'hA5A5_0000 | 32'(i * 17),
                 3'(i + 1), 2'b00, 32'h5A00_C3C3 ^ 32'(i << 20));
        for (int i = 0; i < 8; i++) idle_read("R4", 3'(i), 2'b00);

        // R2 R3 R11: every read mode on every register from both ports
        for (int i = 0; i < 8; i++)
            for (int m = 0; m < 4; m++)
                step("R3", 3'(i), 2'(m), 3'(7 - i), 2'(3 - m),
                     3'd0, 2'b11, 32'h0, 3'd0, 2'b11, 32'h0);

        // R5: half writes, data from low bits, other half kept
        for (int i = 0; i < 8; i++) begin
            step("R5", 3'd0, 2'b11, 3'd0, 2'b11, 3'(i), 2'b01, 32'hDEAD_0000 | 32'(i + 16'h1100),
                 3'd0, 2'b11, 32'h0);
            idle_read("R5", 3'(i), 2'b00);
            step("R5", 3'd0, 2'b11, 3'd0, 2'b11, 3'd0, 2'b11, 32'h0,
                 3'(i), 2'b10, 32'hBEEF_0000 | 32'(i + 16'h2200));
            idle_read("R5", 3'(i), 2'b00);
        end

        // R6: idle writes with matching index and nonzero data
        step("R6", 3'd3, 2'b00, 3'd3, 2'b00, 3'd3, 2'b11, 32'hFFFF_FFFF, 3'd3, 2'b11, 32'hFFFF_FFFF);
        idle_read("R6", 3'd3, 2'b00);

        // R8: same half collision, port 1 wins
        step("R8", 3'd4, 2'b00, 3'd4, 2'b00, 3'd4, 2'b00, 32'h1111_1111, 3'd4, 2'b00, 32'h2222_2222);
        idle_read("R8", 3'd4, 2'b00);
        step("R8", 3'd4, 2'b00, 3'd4, 2'b00, 3'd4, 2'b10, 32'h0000_3333, 3'd4, 2'b10, 32'h0000_4444);
        idle_read("R8", 3'd4, 2'b00);
        step("R8", 3'd4, 2'b00, 3'd4, 2'b00, 3'd4, 2'b00, 32'h5555_6666, 3'd4, 2'b01, 32'h0000_7777);
        idle_read("R8", 3'd4, 2'b00);

        // R9: disjoint halves on one register both land
        step("R9", 3'd6, 2'b00, 3'd6, 2'b00, 3'd6, 2'b01, 32'h0000_8888, 3'd6, 2'b10, 32'h0000_9999);
        idle_read("R9", 3'd6, 2'b00);
        step("R9", 3'd6, 2'b00, 3'd6, 2'b00, 3'd6, 2'b10, 32'h0000_AAAA, 3'd6, 2'b01, 32'h0000_BBBB);
        idle_read("R9", 3'd6, 2'b00);

        // R10: same-cycle read sees the old value, then new
        step("R10", 3'd1, 2'b00, 3'd1, 2'b01, 3'd1, 2'b00, 32'hCAFE_F00D, 3'd0, 2'b11, 32'h0);
        idle_read("R10", 3'd1, 2'b00);

        // R11: mixed sweep driven by an LFSR
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step("R11", lfsr[2:0], lfsr[4:3], lfsr[7:5], lfsr[9:8],
                 lfsr[12:10], lfsr[14:13], {lfsr[15:0], lfsr[31:16]},
                 lfsr[17:15], lfsr[19:18], lfsr ^ 32'h0F0F_F0F0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule